// File: doc/BRIEF.md
# Active-Low Bus Parity Checker

This block watches two control groups on a shared system bus whose signals are all active low. The request group is an address strobe together with a five-bit request code, and a request parity line protects it. The response group is a three-bit status, and a response parity line protects it. Parity is defined on electrical levels. A correct parity line is high when an even number of the covered signals are electrically low, so a fully idle group carries a high parity line.

The block has two jobs. On the generation side, two combinational outputs give the parity level that a driving agent should place on each parity line, computed from the levels present on the bus in the current cycle. On the checking side, two small state machines compare the observed parity lines with those expected levels. The request machine produces a one-clock error pulse after any cycle in which the strobe is asserted and the request parity is wrong. The response machine holds a sticky error flag once a non-idle status arrives with wrong parity, and a clear input releases the flag.

Request state machine: states `REQ_QUIET` and `REQ_FLAG`. From either state, a qualified mismatch (strobe electrically low and wrong parity) moves to `REQ_FLAG`, and any other cycle moves to `REQ_QUIET`. Response state machine: states `RSP_CLEAN` and `RSP_FAULT`. A non-idle mismatch moves `RSP_CLEAN` to `RSP_FAULT`. While in `RSP_FAULT`, a clear with no new mismatch returns to `RSP_CLEAN`, and otherwise the state stays in `RSP_FAULT`.

Top module: `bus_lowpar_top`

## Requirements
- R1: `req_par_expect` is 1 exactly when the count of 0 bits across {`strobe_n`, `req_code_n[4:0]`} (six bits) is even, and 0 when that count is odd.
- R2: When every covered line of a group is 1, that group's expected parity output (`req_par_expect` or `stat_par_expect`) is 1.
- R3: `stat_par_expect` is 1 exactly when the count of 0 bits in `stat_n[2:0]` is even.
- R4: If `strobe_n` is 0 and `req_par_line` differs from `req_par_expect` in a clock cycle, then `req_err_pulse` is 1 for exactly the following cycle. It is 0 after every cycle with correct parity.
- R5: In a cycle where `strobe_n` is 1, the request parity line is ignored, so `req_err_pulse` is 0 in the following cycle whatever level `req_par_line` has.
- R6: If `stat_n` is not 3'b111 and `stat_par_line` differs from `stat_par_expect`, then `stat_err_flag` is 1 from the next cycle on. It stays 1 until a clear takes effect.
- R7: Status 3'b111 is the idle encoding. While the status is idle, `stat_par_line` is not checked, so a low line never sets `stat_err_flag`.
- R8: `err_clear` high for one cycle drops `stat_err_flag` to 0 in the next cycle. If a response mismatch happens in the same cycle as the clear, the set wins and the flag is 1 in the next cycle.
- R9: While `rst_n` is 0, `req_err_pulse` and `stat_err_flag` are 0, and they stay 0 in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_n | input | 1 | Address strobe level, active low |
| req_code_n | input | 5 | Request code levels, active low |
| req_par_line | input | 1 | Observed request parity line level |
| stat_n | input | 3 | Response status levels, active low; 3'b111 means idle |
| stat_par_line | input | 1 | Observed response parity line level |
| err_clear | input | 1 | Clears the sticky response error flag |
| req_par_expect | output | 1 | Request parity level an agent should drive |
| stat_par_expect | output | 1 | Response parity level an agent should drive |
| req_err_pulse | output | 1 | One-cycle request parity error indication |
| stat_err_flag | output | 1 | Sticky response parity error flag |

## Verification
Two of the block's functions can fall in the same cycle. The first pair is a clear of the sticky response flag and a fresh response parity mismatch. The bench drives both in one cycle and expects the flag to read 1 on the next cycle, since the set has priority. It also raises a request mismatch in that same cycle and judges the request pulse separately, which shows that the two groups do not disturb each other. A clear paired with an idle status and a low parity line must drop the flag, because the idle status must not count as a new error.

// File: rtl/bus_lowpar_pkg.sv
package bus_lowpar_pkg;

    typedef enum logic {
        REQ_QUIET = 1'b0,
        REQ_FLAG  = 1'b1
    } req_state_t;

    typedef enum logic {
        RSP_CLEAN = 1'b0,
        RSP_FAULT = 1'b1
    } rsp_state_t;

endpackage

// File: rtl/bus_lowpar_gen.sv
module bus_lowpar_gen #(
    parameter int WIDTH = 6
) (
    input  logic [WIDTH-1:0] lines_n,
    output logic             par_line
);
    // low_odd[i] is 1 when an odd number of lines below index i are electrically low
    logic [WIDTH:0] low_odd;

    assign low_odd[0] = 1'b0;

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_chain
            assign low_odd[g+1] = low_odd[g] ^ ~lines_n[g];
        end
    endgenerate

    // An even count of low lines calls for a high parity line
    assign par_line = ~low_odd[WIDTH];

endmodule

// File: rtl/bus_lowpar_req.sv
module bus_lowpar_req
    import bus_lowpar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    input  logic par_line,
    input  logic par_expect,
    output logic err_pulse
);
    req_state_t state_q, state_d;
    logic       qualified_bad;

    assign qualified_bad = !strobe_n && (par_line != par_expect);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = REQ_QUIET;
        unique case (state_q)
            REQ_QUIET: state_d = qualified_bad ? REQ_FLAG : REQ_QUIET;
            REQ_FLAG:  state_d = qualified_bad ? REQ_FLAG : REQ_QUIET;
        endcase
    end

    always_comb begin
        err_pulse = 1'b0;
        unique case (state_q)
            REQ_QUIET: err_pulse = 1'b0;
            REQ_FLAG:  err_pulse = 1'b1;
        endcase
    end

    // R4: a wrong parity while the strobe is active shows as a pulse next cycle
    assert_bad_req_pulses_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && (par_line != par_expect)) |=> err_pulse);

    // R4: a good-parity cycle is never followed by a pulse
    assert_good_req_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && (par_line == par_expect)) |=> !err_pulse);

    // R5: an inactive strobe leaves the parity line unchecked
    assert_no_strobe_no_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_n |=> !err_pulse);

endmodule

// File: rtl/bus_lowpar_rsp.sv
module bus_lowpar_rsp
    import bus_lowpar_pkg::*;
#(
    parameter int STAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_n,
    input  logic              par_line,
    input  logic              par_expect,
    input  logic              clear,
    output logic              err_flag
);
    localparam logic [STAT_W-1:0] IDLE_CODE = {STAT_W{1'b1}};

    rsp_state_t state_q, state_d;
    logic       stat_idle;
    logic       mismatch;

    assign stat_idle = (stat_n == IDLE_CODE);
    assign mismatch  = !stat_idle && (par_line != par_expect);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RSP_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_CLEAN: state_d = mismatch ? RSP_FAULT : RSP_CLEAN;
            RSP_FAULT: state_d = (clear && !mismatch) ? RSP_CLEAN : RSP_FAULT;
        endcase
    end

    always_comb begin
        err_flag = 1'b0;
        unique case (state_q)
            RSP_CLEAN: err_flag = 1'b0;
            RSP_FAULT: err_flag = 1'b1;
        endcase
    end

    // R6: a non-idle mismatch sets the flag
    assert_mismatch_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_n != IDLE_CODE) && (par_line != par_expect)) |=> err_flag);

    // R6: without a clear the flag holds
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clear) |=> err_flag);

    // R7: an idle status never raises the flag
    assert_idle_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag && (stat_n == IDLE_CODE)) |=> !err_flag);

    // R8: a clear with no fresh mismatch drops the flag
    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && ((stat_n == IDLE_CODE) || (par_line == par_expect))) |=> !err_flag);

endmodule

// File: rtl/bus_lowpar_top.sv
module bus_lowpar_top #(
    parameter int CODE_W = 5,
    parameter int STAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic [CODE_W-1:0] req_code_n,
    input  logic              req_par_line,
    input  logic [STAT_W-1:0] stat_n,
    input  logic              stat_par_line,
    input  logic              err_clear,
    output logic              req_par_expect,
    output logic              stat_par_expect,
    output logic              req_err_pulse,
    output logic              stat_err_flag
);
    localparam int REQ_W = CODE_W + 1;

    bus_lowpar_gen #(.WIDTH(REQ_W)) u_req_gen (
        .lines_n  ({strobe_n, req_code_n}),
        .par_line (req_par_expect)
    );

    bus_lowpar_gen #(.WIDTH(STAT_W)) u_stat_gen (
        .lines_n  (stat_n),
        .par_line (stat_par_expect)
    );

    bus_lowpar_req u_req_chk (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_n   (strobe_n),
        .par_line   (req_par_line),
        .par_expect (req_par_expect),
        .err_pulse  (req_err_pulse)
    );

    bus_lowpar_rsp #(.STAT_W(STAT_W)) u_rsp_chk (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_n     (stat_n),
        .par_line   (stat_par_line),
        .par_expect (stat_par_expect),
        .clear      (err_clear),
        .err_flag   (stat_err_flag)
    );

    // R2: an all-high group calls for a high parity line
    assert_req_all_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (&{strobe_n, req_code_n}) |-> req_par_expect);

    assert_stat_all_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (&stat_n) |-> stat_par_expect);

    // R9: both error outputs leave reset low
    assert_reset_quiet_R9: assert property (@(posedge clk)
        $rose(rst_n) |-> (!req_err_pulse && !stat_err_flag));

endmodule

// File: tb/bus_lowpar_top_bench.sv
module bus_lowpar_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe_n = 1'b1;
    logic [4:0] req_code_n = 5'b11111;
    logic       req_par_line = 1'b1;
    logic [2:0] stat_n = 3'b111;
    logic       stat_par_line = 1'b1;
    logic       err_clear = 1'b0;
    logic       req_par_expect, stat_par_expect, req_err_pulse, stat_err_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_lowpar_top u_bus_lowpar_top (
        .clk             (clk),
        .rst_n           (rst_n),
        .strobe_n        (strobe_n),
        .req_code_n      (req_code_n),
        .req_par_line    (req_par_line),
        .stat_n          (stat_n),
        .stat_par_line   (stat_par_line),
        .err_clear       (err_clear),
        .req_par_expect  (req_par_expect),
        .stat_par_expect (stat_par_expect),
        .req_err_pulse   (req_err_pulse),
        .stat_err_flag   (stat_err_flag)
    );

    // {strobe_n, code_n[4:0], stat_n[2:0], expected req parity, expected status parity}
    localparam logic [10:0] VEC [8] = '{
        11'b1_11111_111_1_1,
        11'b0_11111_110_0_0,
        11'b0_01111_100_1_1,
        11'b0_00000_000_1_0,
        11'b1_10101_011_1_0,
        11'b0_10010_101_1_0,
        11'b1_00001_010_1_1,
        11'b0_11100_001_0_1
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) step();
        check("R9 pulse in reset", req_err_pulse, 1'b0);
        check("R9 flag in reset", stat_err_flag, 1'b0);
        rst_n = 1'b1;
        step();
        check("R9 pulse after release", req_err_pulse, 1'b0);
        check("R9 flag after release", stat_err_flag, 1'b0);

        // Table walk: correct parity driven on both lines
        for (int i = 0; i < 8; i++) begin
            strobe_n      = VEC[i][10];
            req_code_n    = VEC[i][9:5];
            stat_n        = VEC[i][4:2];
            req_par_line  = VEC[i][1];
            stat_par_line = VEC[i][0];
            #1;
            check($sformatf("R1 req parity vec %0d", i), req_par_expect, VEC[i][1]);
            check($sformatf("R3 stat parity vec %0d", i), stat_par_expect, VEC[i][0]);
            if (i == 0) begin
                check("R2 req all high", req_par_expect, 1'b1);
                check("R2 stat all high", stat_par_expect, 1'b1);
            end
            step();
            check($sformatf("R4 no pulse on good parity vec %0d", i), req_err_pulse, 1'b0);
            check($sformatf("R6 no flag on good parity vec %0d", i), stat_err_flag, 1'b0);
        end

        // R4: request mismatch with strobe active, one-cycle pulse
        strobe_n = 1'b0; req_code_n = 5'b11111; req_par_line = 1'b1;
        stat_n = 3'b111; stat_par_line = 1'b1;
        step();
        check("R4 pulse after mismatch", req_err_pulse, 1'b1);
        // R5: wrong parity with the strobe inactive
        strobe_n = 1'b1; req_par_line = 1'b0;
        step();
        check("R5 no pulse with strobe inactive", req_err_pulse, 1'b0);
        step();
        check("R5 still no pulse", req_err_pulse, 1'b0);

        // R7: idle status with a low parity line
        stat_n = 3'b111; stat_par_line = 1'b0;
        step(); step();
        check("R7 idle not checked", stat_err_flag, 1'b0);

        // R6: non-idle mismatch sets a sticky flag
        stat_n = 3'b110; stat_par_line = 1'b1;
        step();
        check("R6 flag set", stat_err_flag, 1'b1);
        stat_n = 3'b111; stat_par_line = 1'b0;
        step(); step();
        check("R6 flag held", stat_err_flag, 1'b1);

        // R8: plain clear
        err_clear = 1'b1;
        step();
        err_clear = 1'b0;
        check("R8 clear drops flag", stat_err_flag, 1'b0);
        step();
        check("R7 stays clean on idle", stat_err_flag, 1'b0);

        // R8: clear and new mismatch together, plus a request mismatch
        err_clear = 1'b1; stat_n = 3'b110; stat_par_line = 1'b1;
        strobe_n = 1'b0; req_code_n = 5'b01111; req_par_line = 1'b0;
        step();
        err_clear = 1'b0; stat_n = 3'b111; stat_par_line = 1'b1;
        strobe_n = 1'b1; req_code_n = 5'b11111; req_par_line = 1'b1;
        check("R8 set wins over clear", stat_err_flag, 1'b1);
        check("R4 pulse alongside response set", req_err_pulse, 1'b1);
        step();
        check("R4 pulse lasts one cycle", req_err_pulse, 1'b0);
        check("R6 flag held after coincidence", stat_err_flag, 1'b1);

        // R9: reset in the middle of a run
        rst_n = 1'b0;
        #1;
        check("R9 async reset clears flag", stat_err_flag, 1'b0);
        step();
        rst_n = 1'b1;
        step();
        check("R9 flag after second reset", stat_err_flag, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule